// File: doc/BRIEF.md
# Arithmetic Status Flag Generator

This block sits beside an integer adder/subtractor and turns its operands into a result and six arithmetic status flags. It takes two operands, a carry/borrow input, an add/subtract select and a width select (byte or 16-bit word). From these it forms the result and the carry, parity, auxiliary carry, zero, sign and overflow flags. The flags are correct at either width. The current flags are available combinationally in the same cycle. A flags register keeps the last values it was given.

The register also holds three control bits: direction, interrupt enable and trap. Arithmetic updates never change these bits. They are written only through their own enable. When neither enable is asserted, the register keeps its contents.

Top module: `flag_gen_top`

## Requirements
- R1: `result` is `op_a + op_b + carry_in` when `do_sub`=0, and `op_a - op_b - carry_in` when `do_sub`=1, modulo 2^width. With `wide`=1 the width is 16 bits. With `wide`=0 the width is 8 bits, the upper bytes of both operands are ignored, and `result[15:8]` is zero.
- R2: `flags_now[0]` (carry) is the unsigned carry out of the top bit at the current width when adding. When subtracting it is the unsigned borrow. For example, byte 255 + 1 sets it.
- R3: `flags_now[1]` (parity) is 1 when `result[7:0]` holds an even number of one bits and 0 when the count is odd. This holds in both widths.
- R4: `flags_now[2]` (auxiliary) is the carry out of bit 3 of the low nibble when adding, and the borrow from the low nibble when subtracting.
- R5: `flags_now[3]` (zero) is 1 exactly when the result at the current width is zero.
- R6: `flags_now[4]` (sign) equals the top bit of the result at the current width: bit 7 for bytes, bit 15 for words.
- R7: `flags_now[5]` (overflow) is 1 on two's-complement overflow at the current width. For example, byte 100 + 50 sets it.
- R8: When `flag_we` is 1 at a clock edge, `flag_reg[5:0]` takes `flags_now`. `flag_reg[8:6]` is not changed by that write.
- R9: When `ctl_we` is 1 at a clock edge, `flag_reg[8:6]` takes `ctl_in`. The bit order is bit 6 direction, bit 7 interrupt enable, bit 8 trap. When neither enable is set, `flag_reg` holds its value.
- R10: A synchronous active-high `rst` clears all of `flag_reg` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_a | input | 16 | First operand |
| op_b | input | 16 | Second operand |
| carry_in | input | 1 | Carry in (add) or borrow in (subtract) |
| do_sub | input | 1 | 1 selects subtraction |
| wide | input | 1 | 1 selects 16-bit width, 0 selects 8-bit width |
| flag_we | input | 1 | Loads the arithmetic flags into the register |
| ctl_we | input | 1 | Loads the control bits into the register |
| ctl_in | input | 3 | Control bits {trap, interrupt, direction} |
| result | output | 16 | Arithmetic result, upper byte zero in byte mode |
| flags_now | output | 6 | Current flags {ovf, sign, zero, aux, parity, carry} |
| flag_reg | output | 9 | Registered flags and control bits |

## Verification
The bench builds the block with its default parameters: a 16-bit word, an 8-bit byte lane and a 4-bit nibble. With these defaults both widths can be exercised in one run. They also put the nibble, byte and word carry boundaries within reach of directed patterns: 0xFF+1, 0x7F+1, 0x7FFF+1, 0-1 and 100+50. Random operands with random width, operation and enable settings then cover the mixing of flag writes and control-bit writes in the same cycle.

// File: rtl/flag_gen_pkg.sv
package flag_gen_pkg;

    localparam int WORD_W = 16;
    localparam int LANE_W = 8;
    localparam int NIB_W  = 4;
    localparam int CTL_W  = 3;

    typedef struct packed {
        logic ovf;
        logic sgn;
        logic zer;
        logic aux;
        logic par;
        logic cry;
    } arith_flags_t;

    localparam int AFL_W = $bits(arith_flags_t);

    typedef struct packed {
        logic         trap;
        logic         intr;
        logic         dirn;
        arith_flags_t ar;
    } flag_word_t;

    localparam int FLW_W = $bits(flag_word_t);

    typedef struct packed {
        logic cry_raw;
        logic aux_raw;
        logic ovf;
    } carry_info_t;

    function automatic logic even_ones(input logic [LANE_W-1:0] v);
        return ~(^v);
    endfunction

endpackage

// File: rtl/flag_adder.sv
module flag_adder
    import flag_gen_pkg::*;
#(
    parameter int DW = WORD_W,
    parameter int LW = LANE_W,
    parameter int NW = NIB_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  logic          cin,
    input  logic          sub,
    input  logic          wide,
    output logic [DW-1:0] res,
    output carry_info_t   cinfo
);
    localparam int LANES = DW / LW;

    logic [DW-1:0] b_eff;
    logic          c0;
    logic [LANES:0] chain;
    logic [DW-1:0] sum_raw;
    logic [NW:0]   nib_sum;

    assign b_eff    = sub ? ~b : b;
    assign c0       = sub ? ~cin : cin;
    assign chain[0] = c0;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic [LW:0] lane_sum;
        assign lane_sum = {1'b0, a[i*LW +: LW]} + {1'b0, b_eff[i*LW +: LW]}
                        + {{LW{1'b0}}, chain[i]};
        assign sum_raw[i*LW +: LW] = lane_sum[LW-1:0];
        assign chain[i+1]          = lane_sum[LW];
    end

    assign nib_sum = {1'b0, a[NW-1:0]} + {1'b0, b_eff[NW-1:0]} + {{NW{1'b0}}, c0};

    logic a_top, b_top, r_top;

    always_comb begin
        if (wide) begin
            res   = sum_raw;
            a_top = a[DW-1];
            b_top = b_eff[DW-1];
            r_top = sum_raw[DW-1];
            cinfo.cry_raw = chain[LANES];
        end else begin
            res   = {{(DW-LW){1'b0}}, sum_raw[LW-1:0]};
            a_top = a[LW-1];
            b_top = b_eff[LW-1];
            r_top = sum_raw[LW-1];
            cinfo.cry_raw = chain[1];
        end
        cinfo.aux_raw = nib_sum[NW];
        cinfo.ovf     = (a_top == b_top) && (r_top != a_top);
    end

    p_narrow_hi_r1: assert property (@(posedge clk) disable iff (rst)
        !wide |-> res[DW-1:LW] == '0)
        else $error("narrow result upper byte not zero");

endmodule

// File: rtl/flag_eval.sv
module flag_eval
    import flag_gen_pkg::*;
#(
    parameter int DW = WORD_W,
    parameter int LW = LANE_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [DW-1:0] res,
    input  logic          wide,
    input  logic          sub,
    input  carry_info_t   cinfo,
    output arith_flags_t  fl
);
    always_comb begin
        fl.cry = cinfo.cry_raw ^ sub;
        fl.aux = cinfo.aux_raw ^ sub;
        fl.ovf = cinfo.ovf;
        fl.par = even_ones(res[LW-1:0]);
        fl.sgn = wide ? res[DW-1] : res[LW-1];
        fl.zer = wide ? (res == '0) : (res[LW-1:0] == '0);
    end

    p_zero_sign_r5: assert property (@(posedge clk) disable iff (rst)
        fl.zer |-> !fl.sgn)
        else $error("zero and sign both set");

endmodule

// File: rtl/flag_store.sv
module flag_store
    import flag_gen_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             flag_we,
    input  logic             ctl_we,
    input  logic [CTL_W-1:0] ctl_in,
    input  arith_flags_t     fl_in,
    output flag_word_t       q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else begin
            if (flag_we) q.ar <= fl_in;
            if (ctl_we)  {q.trap, q.intr, q.dirn} <= ctl_in;
        end
    end

    p_reset_r10: assert property (@(posedge clk)
        rst |=> q == '0)
        else $error("reset did not clear register");

    p_load_r8: assert property (@(posedge clk) disable iff (rst)
        flag_we |=> q.ar == $past(fl_in))
        else $error("arith flags not loaded");

    p_ctl_keep_r8: assert property (@(posedge clk) disable iff (rst)
        !ctl_we |=> {q.trap, q.intr, q.dirn} == $past({q.trap, q.intr, q.dirn}))
        else $error("control bits changed without enable");

    p_ctl_load_r9: assert property (@(posedge clk) disable iff (rst)
        ctl_we |=> {q.trap, q.intr, q.dirn} == $past(ctl_in))
        else $error("control bits not loaded");

    p_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (!flag_we && !ctl_we) |=> $stable(q))
        else $error("register changed with no enable");

endmodule

// File: rtl/flag_gen_top.sv
module flag_gen_top
    import flag_gen_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [WORD_W-1:0] op_a,
    input  logic [WORD_W-1:0] op_b,
    input  logic              carry_in,
    input  logic              do_sub,
    input  logic              wide,
    input  logic              flag_we,
    input  logic              ctl_we,
    input  logic [CTL_W-1:0]  ctl_in,
    output logic [WORD_W-1:0] result,
    output logic [AFL_W-1:0]  flags_now,
    output logic [FLW_W-1:0]  flag_reg
);
    carry_info_t  cinfo;
    arith_flags_t fl;
    flag_word_t   q;

    flag_adder #(.DW(WORD_W), .LW(LANE_W), .NW(NIB_W)) u_add (
        .clk(clk), .rst(rst), .a(op_a), .b(op_b), .cin(carry_in),
        .sub(do_sub), .wide(wide), .res(result), .cinfo(cinfo)
    );

    flag_eval #(.DW(WORD_W), .LW(LANE_W)) u_eval (
        .clk(clk), .rst(rst), .res(result), .wide(wide), .sub(do_sub),
        .cinfo(cinfo), .fl(fl)
    );

    flag_store u_reg (
        .clk(clk), .rst(rst), .flag_we(flag_we), .ctl_we(ctl_we),
        .ctl_in(ctl_in), .fl_in(fl), .q(q)
    );

    assign flags_now = fl;
    assign flag_reg  = q;

    p_sign_r6: assert property (@(posedge clk) disable iff (rst)
        !wide |-> flags_now[4] == result[LANE_W-1])
        else $error("byte sign mismatch");

endmodule

// File: tb/tb_flag_gen_top.sv
`timescale 1ns/1ps
module tb_flag_gen_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] op_a = '0, op_b = '0;
    logic        carry_in = 1'b0, do_sub = 1'b0, wide = 1'b0;
    logic        flag_we = 1'b0, ctl_we = 1'b0;
    logic [2:0]  ctl_in = '0;
    logic [15:0] result;
    logic [5:0]  flags_now;
    logic [8:0]  flag_reg;

    int checks = 0;
    int errors = 0;
    logic [8:0] model_reg = '0;

    always #2.5 clk = ~clk;

    flag_gen_top dut (
        .clk(clk), .rst(rst), .op_a(op_a), .op_b(op_b), .carry_in(carry_in),
        .do_sub(do_sub), .wide(wide), .flag_we(flag_we), .ctl_we(ctl_we),
        .ctl_in(ctl_in), .result(result), .flags_now(flags_now), .flag_reg(flag_reg)
    );

    // Reference: returns {flags[5:0], result[15:0]}
    function automatic logic [21:0] ref_model(input logic [15:0] a, input logic [15:0] b,
                                              input logic ci, input logic sb, input logic wd);
        int w, mask, aa, bb, full, nib, r;
        logic cf, af, pf, zf, sf, of, sa, sbb, sr;
        w    = wd ? 16 : 8;
        mask = (1 << w) - 1;
        aa   = int'(a) & mask;
        bb   = int'(b) & mask;
        if (!sb) begin
            full = aa + bb + int'(ci);
            cf   = ((full >> w) & 1) != 0;
            nib  = (aa & 15) + (bb & 15) + int'(ci);
            af   = nib > 15;
        end else begin
            full = aa - bb - int'(ci);
            cf   = full < 0;
            nib  = (aa & 15) - (bb & 15) - int'(ci);
            af   = nib < 0;
        end
        r   = full & mask;
        sa  = ((aa >> (w-1)) & 1) != 0;
        sbb = ((bb >> (w-1)) & 1) != 0;
        sr  = ((r  >> (w-1)) & 1) != 0;
        of  = sb ? ((sa != sbb) && (sr != sa)) : ((sa == sbb) && (sr != sa));
        pf  = ~(^(r[7:0]));
        zf  = (r == 0);
        sf  = sr;
        return {of, sf, zf, af, pf, cf, r[15:0]};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp_v);
        checks++;
        if (act !== exp_v) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp_v);
        end
    endtask

    task automatic step(input logic [15:0] a, input logic [15:0] b, input logic ci,
                        input logic sb, input logic wd, input logic fwe,
                        input logic cwe, input logic [2:0] cv);
        logic [21:0] e;
        @(negedge clk);
        op_a = a; op_b = b; carry_in = ci; do_sub = sb; wide = wd;
        flag_we = fwe; ctl_we = cwe; ctl_in = cv;
        #1;
        e = ref_model(a, b, ci, sb, wd);
        chk("R1 result", 32'(result), 32'(e[15:0]));
        chk("R2 carry", 32'(flags_now[0]), 32'(e[16]));
        chk("R3 parity", 32'(flags_now[1]), 32'(e[17]));
        chk("R4 aux", 32'(flags_now[2]), 32'(e[18]));
        chk("R5 zero", 32'(flags_now[3]), 32'(e[19]));
        chk("R6 sign", 32'(flags_now[4]), 32'(e[20]));
        chk("R7 overflow", 32'(flags_now[5]), 32'(e[21]));
        if (fwe) model_reg[5:0] = e[21:16];
        if (cwe) model_reg[8:6] = cv;
        @(posedge clk);
        #1;
        chk("R8 R9 register", 32'(flag_reg), 32'(model_reg));
    endtask

    initial begin
        #(5.0 * 150000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h1234_5678));
        repeat (3) @(posedge clk);
        #1;
        chk("R10 reset", 32'(flag_reg), 32'h0);
        @(negedge clk);
        rst = 1'b0;

        // R2 R5 R3 R4: byte 255 + 1 -> 0, carry, zero, parity, aux
        step(16'h00FF, 16'h0001, 0, 0, 0, 1, 0, 3'b000);
        chk("R2 byte 255+1 carry", 32'(flag_reg[0]), 32'h1);
        // R7: byte 100 + 50 overflows
        step(16'd100, 16'd50, 0, 0, 0, 1, 0, 3'b000);
        chk("R7 byte 100+50 overflow", 32'(flag_reg[5]), 32'h1);
        // R1: narrow mode ignores upper operand bytes
        step(16'hAB12, 16'hCD34, 1, 0, 0, 0, 0, 3'b000);
        chk("R1 narrow upper zero", 32'(result[15:8]), 32'h0);
        // R6 R7 word boundary
        step(16'h7FFF, 16'h0001, 0, 0, 1, 1, 0, 3'b000);
        chk("R6 word sign", 32'(flag_reg[4]), 32'h1);
        // R2 R4 borrow in subtraction
        step(16'h0000, 16'h0001, 0, 1, 1, 1, 0, 3'b000);
        chk("R2 word borrow", 32'(flag_reg[0]), 32'h1);
        step(16'h0010, 16'h0001, 0, 1, 0, 1, 0, 3'b000);
        chk("R4 nibble borrow", 32'(flag_reg[2]), 32'h1);
        // R3 parity on low byte only in word mode
        step(16'h0100, 16'h0000, 0, 0, 1, 1, 0, 3'b000);
        chk("R3 word parity low byte", 32'(flag_reg[1]), 32'h1);
        // R9 control load, R8 keeps it across arithmetic writes
        step(16'h0001, 16'h0001, 0, 0, 0, 0, 1, 3'b101);
        step(16'h00FF, 16'h00FF, 1, 1, 0, 1, 0, 3'b010);
        chk("R8 control kept", 32'(flag_reg[8:6]), 32'h5);
        // R9 hold with no enable
        step(16'hFFFF, 16'h0001, 0, 0, 1, 0, 0, 3'b111);
        // both enables together
        step(16'h8000, 16'h8000, 0, 0, 1, 1, 1, 3'b011);

        for (int i = 0; i < 600; i++) begin
            step(16'($urandom), 16'($urandom), 1'($urandom), 1'($urandom),
                 1'($urandom), 1'($urandom), ($urandom % 4) == 0, 3'($urandom));
        end

        // R10 reset mid-run
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        #1;
        chk("R10 reset mid-run", 32'(flag_reg), 32'h0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule